// File: doc/BRIEF.md
# Two-Wire Serial Slave Protocol Engine

This block is the slave end of a two-wire serial bus (SCL clock, SDA data) inside a small nonvolatile memory with a byte-addressed array. It oversamples both bus lines with its own system clock, recognises start and stop conditions, and shifts in a device byte. That byte must carry the fixed type nibble 1010 and the three pin-selected device bits. A matching device byte is acknowledged by pulling SDA low through an open-drain output enable.

Once selected for a write, the engine takes the next byte as the memory pointer and every later byte as data. It hands each data byte to the memory back end as a one-cycle write command and signals a commit when the master closes the transfer with a stop. Once selected for a read, it shifts out the byte at the pointer. It keeps going while the master acknowledges and goes quiet on a not-acknowledge. A dummy write followed by a repeated start turns into a random read. A device byte sent while the back end reports busy is left unacknowledged, so a master can poll until the internal write finishes.

Top module: `tws_slave_engine`

## Requirements
- R1: After reset the engine does not drive SDA and issues no write or commit command.
- R2: A device byte whose bits 7..4 are 1010 and whose bits 3..1 equal `dev_sel_i` is acknowledged (SDA low during the ninth SCL clock) when `mem_busy_i` is low; bit 0 selects read (1) or write (0).
- R3: A device byte with a different type nibble or select field is not acknowledged, and the bytes that follow it are neither acknowledged nor turned into write commands until the next start.
- R4: While `mem_busy_i` is high a matching device byte is not acknowledged; the same byte sent again after busy clears is acknowledged.
- R5: In a write, the byte after the device byte loads the pointer; each later byte is acknowledged and gives one `wr_en_o` pulse with `wr_addr_o` equal to the pointer and `wr_data_o` equal to the byte, after which the pointer steps by one, wrapping from the top address to 0.
- R6: A stop that ends a transfer in which at least one data byte was written gives exactly one single-cycle `wr_commit_o` pulse; a transfer without data bytes gives none.
- R7: In a read, the byte on `rd_data_i` for `rd_addr_o` is sent most significant bit first; the pointer steps by one after each byte, wrapping to 0, and an acknowledge from the master makes the next byte follow.
- R8: After a not-acknowledge from the master the engine releases SDA and drives nothing until the next start.
- R9: A read started directly with a read device byte begins at the pointer left by the previous access.
- R10: A write device byte and a word address followed by a repeated start and a read device byte reads from that word address.
- R11: A start seen in any state, including mid-byte, aborts the byte and restarts device-byte reception; up to nine clocks with SDA high followed by a start always lead to a working access.
- R12: A stop seen in any state returns the engine to idle, so later clocks without a start are ignored.
- R13: The engine begins pulling SDA low only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe_o | output | 1 | Open-drain enable: 1 pulls SDA low |
| dev_sel_i | input | 3 | Pin-strapped device select bits |
| mem_busy_i | input | 1 | Back end is in its internal write cycle |
| rd_addr_o | output | ADDR_W | Current memory pointer, read address |
| rd_data_i | input | 8 | Byte stored at `rd_addr_o` |
| wr_en_o | output | 1 | One-cycle write command |
| wr_addr_o | output | ADDR_W | Address of the write command |
| wr_data_o | output | 8 | Data of the write command |
| wr_commit_o | output | 1 | One-cycle pulse: latch the buffered writes |

## Verification
Every bus edge passes two synchronizer flops and one edge-compare flop before the engine's registers react, so SDA drive, acknowledge and release change on the third system clock after the SCL edge. The bench samples SDA in the middle of each SCL high phase, twelve clocks after the preceding falling edge. Write commands are logged by a monitor on every falling system-clock edge and compared once the transfer's stop has completed, and the commit pulse is counted at least four clocks after the stop edge. A bus-side monitor flags any new SDA pull-down that starts while SCL is high, and a flag of SDA activity covers the windows in which the engine must stay silent.

// File: rtl/tws_pkg.sv
`timescale 1ns/1ps
package tws_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_DEV,
      ST_ADR,
      ST_WR,
      ST_RD
   } tws_state_e;

   localparam int BYTE_W = 8;
endpackage

// File: rtl/tws_bus_sampler.sv
`timescale 1ns/1ps
module tws_bus_sampler #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det,
   output logic sda_s
);
   if (STAGES < 2) begin : g_bad_stages
      $error("tws_bus_sampler: STAGES must be at least 2");
   end

   logic [STAGES-1:0] scl_q, sda_q;
   logic              scl_p, sda_p, scl_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= '1;
         sda_q <= '1;
         scl_p <= 1'b1;
         sda_p <= 1'b1;
      end else begin
         scl_q <= {scl_q[STAGES-2:0], scl_i};
         sda_q <= {sda_q[STAGES-2:0], sda_i};
         scl_p <= scl_q[STAGES-1];
         sda_p <= sda_q[STAGES-1];
      end
   end

   assign scl_s     = scl_q[STAGES-1];
   assign sda_s     = sda_q[STAGES-1];
   assign scl_rise  = scl_s & ~scl_p;
   assign scl_fall  = ~scl_s & scl_p;
   assign start_det = scl_s & scl_p & sda_p & ~sda_s;
   assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/tws_ptr.sv
`timescale 1ns/1ps
module tws_ptr #(
   parameter int ADDR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [7:0]        load_val,
   input  logic              inc,
   output logic [ADDR_W-1:0] ptr
);
   if (ADDR_W < 1 || ADDR_W > 8) begin : g_bad_width
      $error("tws_ptr: ADDR_W must lie in 1..8");
   end

   localparam logic [ADDR_W-1:0] STEP = ADDR_W'(1);
   logic [ADDR_W-1:0] load_cut;

   if (ADDR_W == 8) begin : g_full
      assign load_cut = load_val;
   end else begin : g_trunc
      assign load_cut = load_val[ADDR_W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     ptr <= '0;
      else if (load)  ptr <= load_cut;
      else if (inc)   ptr <= ptr + STEP;
   end
endmodule

// File: rtl/tws_engine.sv
`timescale 1ns/1ps
module tws_engine
   import tws_pkg::*;
#(
   parameter int          ADDR_W    = 8,
   parameter logic [3:0]  TYPE_CODE = 4'b1010
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_rise,
   input  logic              scl_fall,
   input  logic              start_det,
   input  logic              stop_det,
   input  logic              sda_s,
   input  logic [2:0]        dev_sel_i,
   input  logic              mem_busy_i,
   input  logic [ADDR_W-1:0] ptr,
   input  logic [7:0]        rd_data_i,
   output logic              sda_oe_o,
   output logic              ptr_load,
   output logic              ptr_inc,
   output logic [7:0]        rx,
   output logic              wr_en_o,
   output logic [ADDR_W-1:0] wr_addr_o,
   output logic [7:0]        wr_data_o,
   output logic              wr_commit_o
);
   localparam logic [3:0] LAST_BIT = 4'd8;
   localparam logic [3:0] MACK_BIT = 4'd9;

   tws_state_e st;
   logic [3:0] cnt;
   logic       ackph;
   logic       mack;
   logic       pend;
   logic [7:0] tx;
   logic       dev_hit;

   assign dev_hit = (rx[7:4] == TYPE_CODE) && (rx[3:1] == dev_sel_i) && !mem_busy_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st <= ST_IDLE;  cnt <= '0;  ackph <= 1'b0;  mack <= 1'b0;
         pend <= 1'b0;   tx <= '0;   rx <= '0;       sda_oe_o <= 1'b0;
         ptr_load <= 1'b0;  ptr_inc <= 1'b0;
         wr_en_o <= 1'b0;   wr_addr_o <= '0;  wr_data_o <= '0;  wr_commit_o <= 1'b0;
      end else begin
         wr_en_o     <= 1'b0;
         wr_commit_o <= 1'b0;
         ptr_load    <= 1'b0;
         ptr_inc     <= 1'b0;
         if (start_det) begin
            st <= ST_DEV;  cnt <= '0;  ackph <= 1'b0;  sda_oe_o <= 1'b0;
         end else if (stop_det) begin
            st <= ST_IDLE; cnt <= '0;  ackph <= 1'b0;  sda_oe_o <= 1'b0;
            if (pend) begin
               wr_commit_o <= 1'b1;
               pend        <= 1'b0;
            end
         end else if (ackph) begin
            // ninth clock: hold the acknowledge until SCL falls again
            if (scl_fall) begin
               ackph <= 1'b0;
               cnt   <= '0;
               if (st == ST_RD) begin
                  tx       <= rd_data_i;
                  sda_oe_o <= ~rd_data_i[7];
               end else begin
                  sda_oe_o <= 1'b0;
               end
            end
         end else if (st == ST_RD) begin
            if (scl_rise) begin
               cnt <= cnt + 4'd1;
               if (cnt == LAST_BIT) mack <= ~sda_s;
            end
            if (scl_fall) begin
               if (cnt == MACK_BIT) begin
                  if (mack) begin
                     tx       <= rd_data_i;
                     sda_oe_o <= ~rd_data_i[7];
                     cnt      <= '0;
                  end else begin
                     st       <= ST_IDLE;
                     sda_oe_o <= 1'b0;
                  end
               end else if (cnt == LAST_BIT) begin
                  sda_oe_o <= 1'b0;
                  ptr_inc  <= 1'b1;
               end else if (cnt != 4'd0) begin
                  sda_oe_o <= ~tx[6];
                  tx       <= {tx[6:0], 1'b0};
               end
            end
         end else if (st != ST_IDLE) begin
            if (scl_rise && cnt != LAST_BIT) begin
               rx  <= {rx[6:0], sda_s};
               cnt <= cnt + 4'd1;
            end
            if (scl_fall && cnt == LAST_BIT) begin
               unique case (st)
                  ST_DEV: begin
                     if (dev_hit) begin
                        ackph    <= 1'b1;
                        sda_oe_o <= 1'b1;
                        st       <= rx[0] ? ST_RD : ST_ADR;
                     end else begin
                        st <= ST_IDLE;
                     end
                  end
                  ST_ADR: begin
                     ackph    <= 1'b1;
                     sda_oe_o <= 1'b1;
                     ptr_load <= 1'b1;
                     st       <= ST_WR;
                  end
                  ST_WR: begin
                     ackph     <= 1'b1;
                     sda_oe_o  <= 1'b1;
                     wr_en_o   <= 1'b1;
                     wr_addr_o <= ptr;
                     wr_data_o <= rx;
                     ptr_inc   <= 1'b1;
                     pend      <= 1'b1;
                  end
                  default: ;
               endcase
            end
         end
      end
   end
endmodule

// File: rtl/tws_slave_engine.sv
`timescale 1ns/1ps
module tws_slave_engine #(
   parameter int         SYNC_STAGES = 2,
   parameter int         ADDR_W      = 8,
   parameter logic [3:0] TYPE_CODE   = 4'b1010
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   output logic              sda_oe_o,
   input  logic [2:0]        dev_sel_i,
   input  logic              mem_busy_i,
   output logic [ADDR_W-1:0] rd_addr_o,
   input  logic [7:0]        rd_data_i,
   output logic              wr_en_o,
   output logic [ADDR_W-1:0] wr_addr_o,
   output logic [7:0]        wr_data_o,
   output logic              wr_commit_o
);
   logic scl_rise, scl_fall, start_det, stop_det, sda_s;
   logic ptr_load, ptr_inc;
   logic [7:0] rx;

   tws_bus_sampler #(.STAGES(SYNC_STAGES)) u_sampler (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_i     (scl_i),
      .sda_i     (sda_i),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_det (start_det),
      .stop_det  (stop_det),
      .sda_s     (sda_s)
   );

   tws_ptr #(.ADDR_W(ADDR_W)) u_ptr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (ptr_load),
      .load_val (rx),
      .inc      (ptr_inc),
      .ptr      (rd_addr_o)
   );

   tws_engine #(.ADDR_W(ADDR_W), .TYPE_CODE(TYPE_CODE)) u_engine (
      .clk         (clk),
      .rst_n       (rst_n),
      .scl_rise    (scl_rise),
      .scl_fall    (scl_fall),
      .start_det   (start_det),
      .stop_det    (stop_det),
      .sda_s       (sda_s),
      .dev_sel_i   (dev_sel_i),
      .mem_busy_i  (mem_busy_i),
      .ptr         (rd_addr_o),
      .rd_data_i   (rd_data_i),
      .sda_oe_o    (sda_oe_o),
      .ptr_load    (ptr_load),
      .ptr_inc     (ptr_inc),
      .rx          (rx),
      .wr_en_o     (wr_en_o),
      .wr_addr_o   (wr_addr_o),
      .wr_data_o   (wr_data_o),
      .wr_commit_o (wr_commit_o)
   );
endmodule

// File: rtl/tws_slave_engine_chk.sv
`timescale 1ns/1ps
module tws_slave_engine_chk #(
   parameter int ADDR_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              scl_i,
   input logic              sda_i,
   input logic              sda_oe_o,
   input logic              wr_en_o,
   input logic              wr_commit_o,
   input logic [ADDR_W-1:0] wr_addr_o,
   input logic [ADDR_W-1:0] rd_addr_o
);
   localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

   // R13: a new pull-down of SDA only begins while SCL is low
   p_oe_rise_scl_low_r13: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_oe_o) |-> !scl_i);

   // R5: write commands are single-cycle pulses
   p_wr_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en_o |=> !wr_en_o);

   // R5: the pointer moves one past the address just written
   p_wr_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en_o |=> (rd_addr_o == $past(wr_addr_o) + ONE));

   // R6: commit is a single-cycle pulse
   p_commit_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
      wr_commit_o |=> !wr_commit_o);

   // R6: commit only follows a stop, with both lines released high
   p_commit_at_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
      wr_commit_o |-> (scl_i && sda_i));
endmodule

bind tws_slave_engine tws_slave_engine_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .scl_i       (scl_i),
   .sda_i       (sda_i),
   .sda_oe_o    (sda_oe_o),
   .wr_en_o     (wr_en_o),
   .wr_commit_o (wr_commit_o),
   .wr_addr_o   (wr_addr_o),
   .rd_addr_o   (rd_addr_o)
);

// File: tb/tws_slave_engine_tb_top.sv
`timescale 1ns/1ps
module tws_slave_engine_tb_top;
   localparam int         HALF  = 8;
   localparam logic [7:0] DEV_W = 8'hAA;  // 1010 101 0
   localparam logic [7:0] DEV_R = 8'hAB;  // 1010 101 1

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic       rst_n = 1'b0;
   logic       m_scl = 1'b1, m_sda = 1'b1;
   logic [2:0] sel   = 3'b101;
   logic       busy  = 1'b0;
   logic       sda_oe;
   wire        sda_bus = m_sda & ~sda_oe;
   logic [7:0] rd_addr, wr_addr, wr_data, rd_data;
   logic       wr_en, wr_commit;

   logic [7:0] bmem [256];
   logic [7:0] emem [256];
   logic [7:0] wbuf [8];
   logic [7:0] wlog_a [512];
   logic [7:0] wlog_d [512];
   int  wn = 0, cn = 0, viol = 0, n_chk = 0, n_bad = 0;
   bit  oe_seen = 0, oe_q = 0, done = 0;
   logic [7:0] exp_ptr = 8'h00;

   assign rd_data = bmem[rd_addr];

   tws_slave_engine dut_i (
      .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_bus), .sda_oe_o(sda_oe),
      .dev_sel_i(sel), .mem_busy_i(busy), .rd_addr_o(rd_addr), .rd_data_i(rd_data),
      .wr_en_o(wr_en), .wr_addr_o(wr_addr), .wr_data_o(wr_data), .wr_commit_o(wr_commit)
   );

   // back-end model and bus monitor
   always @(negedge clk) begin
      if (wr_en) begin
         wlog_a[wn % 512] = wr_addr;
         wlog_d[wn % 512] = wr_data;
         bmem[wr_addr]    = wr_data;
         wn++;
      end
      if (wr_commit) cn++;
      if (sda_oe && !oe_q && m_scl) viol++;
      if (sda_oe) oe_seen = 1;
      oe_q = sda_oe;
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
   endtask

   task automatic clks(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bus_start();
      m_sda = 1; clks(HALF); m_scl = 1; clks(HALF); m_sda = 0; clks(HALF); m_scl = 0;
   endtask

   task automatic bus_stop();
      m_sda = 0; clks(HALF); m_scl = 1; clks(HALF); m_sda = 1; clks(HALF);
   endtask

   task automatic send_byte(input logic [7:0] b, output bit ack);
      for (int i = 7; i >= 0; i--) begin
         m_sda = b[i]; clks(HALF); m_scl = 1; clks(HALF); m_scl = 0;
      end
      m_sda = 1; clks(HALF); m_scl = 1; clks(HALF/2);
      ack = !sda_bus;
      clks(HALF/2); m_scl = 0;
   endtask

   task automatic recv_byte(input bit mack, output logic [7:0] b);
      m_sda = 1;
      for (int i = 7; i >= 0; i--) begin
         clks(HALF); m_scl = 1; clks(HALF/2);
         b[i] = sda_bus;
         clks(HALF/2); m_scl = 0;
      end
      m_sda = !mack; clks(HALF); m_scl = 1; clks(HALF); m_scl = 0;
   endtask

   task automatic clock_ones(input int n);
      m_sda = 1;
      for (int i = 0; i < n; i++) begin
         clks(HALF); m_scl = 1; clks(HALF); m_scl = 0;
      end
   endtask

   task automatic wr_txn(input logic [7:0] a, input int n, input string tag);
      int w0, c0;
      bit ak;
      logic [7:0] ad;
      w0 = wn; c0 = cn;
      bus_start();
      send_byte(DEV_W, ak); chk(ak, {tag, " write device ack"}, ak, 1);
      send_byte(a, ak);     chk(ak, "R5 word address ack", ak, 1);
      for (int i = 0; i < n; i++) begin
         send_byte(wbuf[i], ak); chk(ak, "R5 data byte ack", ak, 1);
         ad = a + 8'(i);
         emem[ad] = wbuf[i];
      end
      bus_stop(); clks(4);
      chk(wn == w0 + n, "R5 write command count", wn - w0, n);
      for (int i = 0; i < n; i++) begin
         ad = a + 8'(i);
         chk(wlog_a[(w0 + i) % 512] == ad, "R5 write address", wlog_a[(w0 + i) % 512], ad);
         chk(wlog_d[(w0 + i) % 512] == wbuf[i], "R5 write data", wlog_d[(w0 + i) % 512], wbuf[i]);
      end
      chk(cn == c0 + 1, "R6 commit after stop", cn - c0, 1);
      exp_ptr = a + 8'(n);
   endtask

   task automatic rd_txn(input bit rnd, input logic [7:0] a, input int n, input string tag);
      bit ak;
      logic [7:0] b, p;
      p = rnd ? a : exp_ptr;
      bus_start();
      if (rnd) begin
         send_byte(DEV_W, ak); chk(ak, "R10 dummy write device ack", ak, 1);
         send_byte(a, ak);     chk(ak, "R10 dummy write address ack", ak, 1);
         bus_start();
      end
      send_byte(DEV_R, ak); chk(ak, "R2 read device ack", ak, 1);
      for (int i = 0; i < n; i++) begin
         recv_byte(i < n - 1, b);
         chk(b == emem[p], {tag, " read byte"}, b, emem[p]);
         p = p + 8'd1;
      end
      bus_stop();
      exp_ptr = p;
   endtask

   initial begin
      for (int i = 0; i < 256; i++) begin
         bmem[i] = 8'h00;
         emem[i] = 8'h00;
      end
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         summary();
         $finish;
      end
   end

   initial begin
      bit ak;
      int w0, c0, seed;
      logic [7:0] b, a;
      int n;
      clks(5); rst_n = 1; clks(5);
      // R1
      chk(sda_oe == 0, "R1 SDA released after reset", sda_oe, 0);
      chk(wr_en == 0 && wr_commit == 0, "R1 no command after reset", {wr_en, wr_commit}, 0);

      // R5 wrap from FE through 00, R2 ack
      wbuf[0] = 8'h3C; wbuf[1] = 8'hC5; wbuf[2] = 8'h81;
      wr_txn(8'hFE, 3, "R2");
      // R10 random read with wrap, R7
      rd_txn(1, 8'hFE, 3, "R7");
      // R9 current address continues at 01
      wbuf[0] = 8'h5A; wr_txn(8'h01, 1, "R2");
      rd_txn(1, 8'h00, 1, "R10");
      rd_txn(0, 8'h00, 1, "R9");

      // R3 select mismatch and type mismatch
      w0 = wn; c0 = cn;
      bus_start();
      send_byte(8'hA4, ak); chk(!ak, "R3 select mismatch no ack", ak, 0);
      send_byte(8'h10, ak); chk(!ak, "R3 following byte no ack", ak, 0);
      send_byte(8'h55, ak); chk(!ak, "R3 data byte no ack", ak, 0);
      bus_stop();
      bus_start();
      send_byte(8'hBA, ak); chk(!ak, "R3 type mismatch no ack", ak, 0);
      bus_stop(); clks(4);
      chk(wn == w0 && cn == c0, "R3 no write after mismatch", wn - w0, 0);

      // R4 busy polling, and R6 no commit without data
      busy = 1;
      for (int k = 0; k < 3; k++) begin
         bus_start(); send_byte(DEV_W, ak);
         chk(!ak, "R4 no ack while busy", ak, 0);
         bus_stop();
      end
      busy = 0; c0 = cn;
      bus_start(); send_byte(DEV_W, ak);
      chk(ak, "R4 ack after busy clears", ak, 1);
      bus_stop(); clks(4);
      chk(cn == c0, "R6 no commit without data", cn - c0, 0);

      // R8 NACK release
      rd_txn(0, 8'h00, 1, "R8");
      bus_start(); send_byte(DEV_R, ak);
      recv_byte(0, b);
      chk(b == emem[exp_ptr], "R8 last byte", b, emem[exp_ptr]);
      exp_ptr = exp_ptr + 8'd1;
      oe_seen = 0;
      recv_byte(0, b);
      chk(b == 8'hFF && !oe_seen, "R8 SDA released after NACK", b, 8'hFF);
      bus_stop();

      // R11 recovery from mid-read, and start in mid-write byte
      bus_start(); send_byte(DEV_R, ak);
      clock_ones(3); clock_ones(9);
      wbuf[0] = 8'h96; wr_txn(8'h40, 1, "R11");
      bus_start(); send_byte(DEV_W, ak); clock_ones(4);
      wbuf[0] = 8'h17; wbuf[1] = 8'hE2; wr_txn(8'h60, 2, "R11");
      rd_txn(1, 8'h40, 1, "R11");

      // R12 stop mid-byte then clocks without start
      w0 = wn;
      bus_start(); send_byte(DEV_W, ak); clock_ones(3);
      bus_stop();
      oe_seen = 0;
      send_byte(8'hAA, ak); chk(!ak, "R12 no ack after stop", ak, 0);
      send_byte(8'hAA, ak); chk(!ak, "R12 still idle", ak, 0);
      chk(!oe_seen && wn == w0, "R12 engine silent", oe_seen, 0);

      // constrained random mix
      seed = $urandom(32'h1D5E);
      for (int it = 0; it < 20; it++) begin
         a = 8'($urandom_range(0, 255));
         n = $urandom_range(1, 4);
         for (int i = 0; i < n; i++) wbuf[i] = 8'($urandom_range(0, 255));
         wr_txn(a, n, "R2");
         rd_txn(1, a, n, "R10");
         if ($urandom_range(0, 1) == 1) rd_txn(0, 8'h00, 2, "R9");
      end

      chk(viol == 0, "R13 drive begins only with SCL low", viol, 0);
      done = 1;
      summary();
      $finish;
   end
endmodule